// File: doc/BRIEF.md
# Serial-Loaded Bank Register Interface

This block sits on the processor's write path for the upper half of the address space. Each write carries a single useful data bit. The block collects five such bits, least significant first, into a 5-bit value. On the fifth accepted write it stores that value in one of four registers: control, pattern bank A, pattern bank B or program bank. Two address lines, sampled on that fifth write, choose the register. The decoded fields of those registers drive the downstream bank translation and screen mirroring logic:

- mirroring mode
- program banking mode
- pattern banking granularity
- bank numbers
- the work-RAM disable flag
- which pattern register was loaded last

A write with data bit 7 high does not shift. It empties the collector and forces the program mode field to 3, leaving the other control bits as they were. Once a write is accepted, the next write is accepted no sooner than two clocks later, so a write one clock later is dropped. A soft reset input does the same work as a bit-7 write. The asynchronous hard reset restores every power-on default, including the lockout and the RAM-disable flag. A one-cycle pulse marks every register update.

Top module: `serial_mapper_regs`

## Requirements
- R1: After hard reset the control register holds 0x0C: mirror_o=0, prg_mode_o=3 and chr_4k_o=0. Both pattern banks are 0, prg_bank_o=0 and last_chr1_o=0. prg_ram_off_o equals parameter REV_A (0 by default), and commit_o=0.
- R2: Each accepted write with wr_data_i[7]=0 shifts the collector right and places wr_data_i[0] at its bit 4. The first write therefore supplies bit 0 of the stored value and the fifth write supplies bit 4.
- R3: The fifth accepted data write stores the value in the register named by addr_sel_i on that write: 0 is control, 1 is pattern bank A, 2 is pattern bank B and 3 is program. The addr_sel_i values of the four earlier writes have no effect.
- R4: After one to four accepted data writes, no register output changes and commit_o stays 0.
- R5: An accepted write with wr_data_i[7]=1 empties the collector and sets control bits 3:2 to 11. Control bits 4 and 1:0 keep their values, and the next five data writes form a complete new value.
- R6: A write presented one clock after an accepted write is ignored. A write presented two clocks after an accepted write is accepted.
- R7: The control register fields are: bits 1:0 mirroring (0 = single-screen lower, 1 = single-screen upper, 2 = vertical, 3 = horizontal), bits 3:2 program mode and bit 4 the 4K pattern mode.
- R8: All five bits of a value stored in a pattern bank register appear on its output. For the program register, bits 3:0 give prg_bank_o and bit 4 gives prg_ram_off_o (1 = disabled).
- R9: last_chr1_o goes to 0 when pattern bank A is stored and to 1 when pattern bank B is stored. Stores to control or program leave it unchanged.
- R10: commit_o is high for exactly one cycle after each register store, each bit-7 write and each soft reset, and is low otherwise.
- R11: soft_rst_i empties the collector and forces control bits 3:2 to 11. A write presented in the same cycle is discarded.
- R12: Hard reset also clears a partly filled collector and returns prg_ram_off_o to its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous hard reset, active low |
| soft_rst_i | input | 1 | Soft reset: empty the collector and force program mode 3 |
| wr_en_i | input | 1 | Write strobe for the upper address half |
| addr_sel_i | input | 2 | Address bits 14:13, select the target register |
| wr_data_i | input | 8 | Write data; bit 7 is the collector reset, bit 0 is the serial bit |
| mirror_o | output | 2 | Mirroring mode |
| prg_mode_o | output | 2 | Program banking mode |
| chr_4k_o | output | 1 | 1 = two independent 4K pattern banks |
| chr_bank0_o | output | 5 | Pattern bank A number |
| chr_bank1_o | output | 5 | Pattern bank B number |
| prg_bank_o | output | 4 | Program bank number |
| prg_ram_off_o | output | 1 | Work RAM disabled |
| last_chr1_o | output | 1 | 1 = pattern bank B was stored most recently |
| commit_o | output | 1 | One-cycle register update pulse |

## Verification
The collision that matters is a soft reset in the same cycle as a write that the lockout would otherwise accept. The bench first puts two bits into the collector, then raises soft_rst_i and wr_en_i together. It expects the forced program mode and a commit pulse. It then loads a full five-bit value and checks that the value arrives exactly, which shows both the discarded write and the cleared bits. A second overlap is a burst of writes held on every clock against the lockout: only every other write may enter the collector, which the bench judges from the value stored after two more spaced writes.

// File: rtl/smr_pkg.sv
package smr_pkg;
    localparam int VAL_W = 5;
    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CHRA = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CHRB = 2'd2;
    localparam logic [SEL_W-1:0] SEL_PRG  = 2'd3;

    // control bits 3:2 forced to 11 by soft reset and bit-7 writes
    localparam logic [VAL_W-1:0] MODE_FORCE = VAL_W'(12);

    typedef struct packed {
        logic [VAL_W-1:0] ctrl;
        logic [VAL_W-1:0] chra;
        logic [VAL_W-1:0] chrb;
        logic [VAL_W-1:0] prg;
        logic             last_b;
    } map_regs_t;
endpackage

// File: rtl/smr_lockout.sv
module smr_lockout #(
    parameter int LOCK_CYCLES = 2,
    localparam int CW = $clog2(LOCK_CYCLES + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic accept_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        accept_o = req_i && (cnt_q == '0);
        cnt_d    = cnt_q;
        if (accept_o) begin
            cnt_d = CW'(LOCK_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/smr_shifter.sv
module smr_shifter #(
    parameter int VAL_W = 5,
    localparam int NW = $clog2(VAL_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic             full_o,
    output logic [VAL_W-1:0] value_o
);
    typedef struct packed {
        logic [VAL_W-1:0] bits;
        logic [NW-1:0]    num;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        value_o = {bit_i, sh_q.bits[VAL_W-1:1]};
        full_o  = shift_i && (sh_q.num == NW'(VAL_W - 1));
        sh_d    = sh_q;
        if (clear_i || full_o) begin
            sh_d = '0;
        end else if (shift_i) begin
            sh_d.bits = value_o;
            sh_d.num  = sh_q.num + NW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end
endmodule

// File: rtl/smr_regfile.sv
module smr_regfile
    import smr_pkg::*;
#(
    parameter bit REV_A = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             store_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [VAL_W-1:0] value_i,
    input  logic             force_i,
    output map_regs_t        regs_o,
    output logic             pulse_o
);
    localparam logic [VAL_W-1:0] PRG_RESET = VAL_W'(REV_A) << (VAL_W - 1);
    localparam map_regs_t REGS_RESET = '{
        ctrl:   MODE_FORCE,
        chra:   '0,
        chrb:   '0,
        prg:    PRG_RESET,
        last_b: 1'b0
    };

    map_regs_t regs_d, regs_q;
    logic      pulse_d, pulse_q;

    always_comb begin
        regs_d  = regs_q;
        pulse_d = store_i || force_i;
        if (force_i) begin
            regs_d.ctrl = regs_q.ctrl | MODE_FORCE;
        end else if (store_i) begin
            unique case (sel_i)
                SEL_CTRL: regs_d.ctrl = value_i;
                SEL_CHRA: begin
                    regs_d.chra   = value_i;
                    regs_d.last_b = 1'b0;
                end
                SEL_CHRB: begin
                    regs_d.chrb   = value_i;
                    regs_d.last_b = 1'b1;
                end
                default:  regs_d.prg = value_i;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q  <= REGS_RESET;
            pulse_q <= 1'b0;
        end else begin
            regs_q  <= regs_d;
            pulse_q <= pulse_d;
        end
    end

    assign regs_o  = regs_q;
    assign pulse_o = pulse_q;
endmodule

// File: rtl/serial_mapper_regs.sv
module serial_mapper_regs
    import smr_pkg::*;
#(
    parameter bit REV_A       = 1'b0,
    parameter int LOCK_CYCLES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             soft_rst_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] addr_sel_i,
    input  logic [7:0]       wr_data_i,
    output logic [1:0]       mirror_o,
    output logic [1:0]       prg_mode_o,
    output logic             chr_4k_o,
    output logic [VAL_W-1:0] chr_bank0_o,
    output logic [VAL_W-1:0] chr_bank1_o,
    output logic [VAL_W-2:0] prg_bank_o,
    output logic             prg_ram_off_o,
    output logic             last_chr1_o,
    output logic             commit_o
);
    logic             accept_w;
    logic             reset_wr_w;
    logic             shift_w;
    logic             clear_w;
    logic             full_w;
    logic [VAL_W-1:0] value_w;
    map_regs_t        regs_w;
    logic             unused_data_bits;

    assign unused_data_bits = ^wr_data_i[6:1];

    smr_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (wr_en_i && !soft_rst_i),
        .accept_o (accept_w)
    );

    always_comb begin
        reset_wr_w = accept_w && wr_data_i[7];
        shift_w    = accept_w && !wr_data_i[7];
        clear_w    = soft_rst_i || reset_wr_w;
    end

    smr_shifter #(.VAL_W(VAL_W)) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear_w),
        .shift_i (shift_w),
        .bit_i   (wr_data_i[0]),
        .full_o  (full_w),
        .value_o (value_w)
    );

    smr_regfile #(.REV_A(REV_A)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .store_i (full_w),
        .sel_i   (addr_sel_i),
        .value_i (value_w),
        .force_i (clear_w),
        .regs_o  (regs_w),
        .pulse_o (commit_o)
    );

    always_comb begin
        mirror_o      = regs_w.ctrl[1:0];
        prg_mode_o    = regs_w.ctrl[3:2];
        chr_4k_o      = regs_w.ctrl[4];
        chr_bank0_o   = regs_w.chra;
        chr_bank1_o   = regs_w.chrb;
        prg_bank_o    = regs_w.prg[VAL_W-2:0];
        prg_ram_off_o = regs_w.prg[VAL_W-1];
        last_chr1_o   = regs_w.last_b;
    end
endmodule

// File: rtl/smr_checker.sv
module smr_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       soft_rst_i,
    input logic       accept_i,
    input logic       bit7_i,
    input logic       commit_i,
    input logic [1:0] prg_mode_i,
    input logic [4:0] chra_i,
    input logic [4:0] chrb_i,
    input logic [3:0] prg_bank_i
);
    AST_LOCK_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_i |=> !accept_i); // R6

    AST_RESET_WRITE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && bit7_i) |=> (prg_mode_i == 2'b11)); // R5

    AST_SOFT_FORCES_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (prg_mode_i == 2'b11)); // R11

    AST_BANKS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_i |-> ($stable(chra_i) && $stable(chrb_i) && $stable(prg_bank_i))); // R4

    AST_COMMIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && $past(commit_i)) |-> ($past(soft_rst_i) || $past(soft_rst_i, 2))); // R10
endmodule

bind serial_mapper_regs smr_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .accept_i   (accept_w),
    .bit7_i     (wr_data_i[7]),
    .commit_i   (commit_o),
    .prg_mode_i (prg_mode_o),
    .chra_i     (chr_bank0_o),
    .chrb_i     (chr_bank1_o),
    .prg_bank_i (prg_bank_o)
);

// File: tb/serial_mapper_regs_tb_top.sv
module serial_mapper_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [7:0] data = 8'd0;
    logic [1:0] mirror, prg_mode;
    logic       chr_4k, ram_off, last_b, commit;
    logic [4:0] chra, chrb;
    logic [3:0] prg_bank;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    serial_mapper_regs dut_i (
        .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .wr_en_i(wr_en),
        .addr_sel_i(sel), .wr_data_i(data), .mirror_o(mirror), .prg_mode_o(prg_mode),
        .chr_4k_o(chr_4k), .chr_bank0_o(chra), .chr_bank1_o(chrb), .prg_bank_o(prg_bank),
        .prg_ram_off_o(ram_off), .last_chr1_o(last_b), .commit_o(commit)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one write accepted at the next edge; cm is commit seen after that edge
    task automatic wr(input logic [1:0] s, input logic [7:0] d, output logic cm);
        sel = s; data = d; wr_en = 1'b1;
        @(negedge clk);
        cm = commit;
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic load5(input logic [1:0] s, input logic [4:0] v, input string req);
        logic cm;
        for (int i = 0; i < 5; i++) begin
            wr(s, {7'd0, v[i]}, cm);
            check(req, int'(cm), (i == 4) ? 1 : 0);
        end
    endtask

    task automatic t_reset;
        check("R1 mirror", mirror, 0);
        check("R1 prg_mode", prg_mode, 3);
        check("R1 chr_4k", chr_4k, 0);
        check("R1 chra", chra, 0);
        check("R1 chrb", chrb, 0);
        check("R1 prg_bank", prg_bank, 0);
        check("R1 ram_off", ram_off, 0);
        check("R1 last", last_b, 0);
        check("R1 commit", commit, 0);
    endtask

    task automatic t_control;
        logic cm;
        logic [4:0] v = 5'b10110;
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, {7'd0, v[i]}, cm);
            check("R4 no commit", cm, 0);
        end
        check("R4 mirror held", mirror, 0);
        check("R4 mode held", prg_mode, 3);
        wr(2'd0, {7'd0, v[4]}, cm);
        check("R10 commit", cm, 1);
        check("R7 mirror", mirror, 2);
        check("R7 prg_mode", prg_mode, 1);
        check("R7 chr_4k", chr_4k, 1);
        check("R10 pulse gone", commit, 0);
    endtask

    task automatic t_chr;
        load5(2'd1, 5'h15, "R2 chra load");
        check("R8 chra", chra, 'h15);
        check("R9 last A", last_b, 0);
        load5(2'd2, 5'h0A, "R2 chrb load");
        check("R8 chrb", chrb, 'h0A);
        check("R9 last B", last_b, 1);
        load5(2'd0, 5'h0C, "R3 ctrl load");
        check("R9 last kept", last_b, 1);
        check("R7 ctrl mirror", mirror, 0);
    endtask

    task automatic t_prg;
        load5(2'd3, 5'h1B, "R3 prg load");
        check("R8 prg_bank", prg_bank, 'hB);
        check("R8 ram_off", ram_off, 1);
    endtask

    task automatic t_addr_last;
        logic cm;
        logic [4:0] v = 5'h06;
        for (int i = 0; i < 4; i++) wr(2'd3, {7'd0, v[i]}, cm);
        wr(2'd1, {7'd0, v[4]}, cm);
        check("R3 last sel commit", cm, 1);
        check("R3 chra by last sel", chra, 6);
        check("R3 prg untouched", prg_bank, 'hB);
        check("R3 ram_off untouched", ram_off, 1);
    endtask

    task automatic t_reset_write;
        logic cm;
        load5(2'd0, 5'h01, "R5 ctrl setup");
        check("R5 setup mode", prg_mode, 0);
        wr(2'd0, 8'h01, cm);
        wr(2'd0, 8'h00, cm);
        wr(2'd0, 8'h81, cm);
        check("R5 commit on bit7", cm, 1);
        check("R5 mode forced", prg_mode, 3);
        check("R5 mirror kept", mirror, 1);
        check("R5 chr_4k kept", chr_4k, 0);
        load5(2'd2, 5'h13, "R5 fresh count");
        check("R5 chrb exact", chrb, 'h13);
    endtask

    task automatic t_lockout;
        logic cm;
        wr(2'd1, 8'h80, cm);
        sel = 2'd1; data = 8'h01; wr_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R6 burst no commit", commit, 0);
        end
        wr_en = 1'b0;
        @(negedge clk);
        check("R6 chra held", chra, 6);
        wr(2'd1, 8'h00, cm);
        check("R6 fourth bit", cm, 0);
        wr(2'd1, 8'h00, cm);
        check("R6 commit", cm, 1);
        check("R6 chra value", chra, 7);
    endtask

    task automatic t_soft;
        logic cm;
        load5(2'd0, 5'h10, "R11 ctrl setup");
        wr(2'd1, 8'h01, cm);
        wr(2'd1, 8'h01, cm);
        soft_rst = 1'b1; wr_en = 1'b1; sel = 2'd1; data = 8'h01;
        @(negedge clk);
        soft_rst = 1'b0; wr_en = 1'b0;
        check("R10 soft commit", commit, 1);
        check("R11 mode forced", prg_mode, 3);
        check("R11 chr_4k kept", chr_4k, 1);
        check("R11 mirror kept", mirror, 0);
        @(negedge clk);
        load5(2'd1, 5'h09, "R11 after soft");
        check("R11 chra exact", chra, 9);
    endtask

    task automatic t_hard;
        logic cm;
        wr(2'd2, 8'h01, cm);
        wr(2'd2, 8'h01, cm);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 ram_off default", ram_off, 0);
        check("R12 mode", prg_mode, 3);
        check("R12 chr_4k", chr_4k, 0);
        check("R12 chra", chra, 0);
        check("R12 last", last_b, 0);
        load5(2'd2, 5'h11, "R12 buffer cleared");
        check("R12 chrb exact", chrb, 'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_control();
        t_chr();
        t_prg();
        t_addr_last();
        t_reset_write();
        t_lockout();
        t_soft();
        t_hard();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule